// File: doc/BRIEF.md
# Card slot detect and status registers

This block is a small memory-mapped register set sitting beside a removable-card slot. It answers reads of two fixed words (an identification word and an address-decode word), a reserved programming word that reads zero, and a status word. The status word combines a live write-protect level with a latched card-insert event.

A card-insert event raises an interrupt. The interrupt stays high until software clears the insert bit by writing a one to it. Both slot inputs are asynchronous to the bus clock, so each passes through a two-flop synchroniser before use. The insert event is taken on the rising edge of the synchronised level.

The bus side is a single-cycle register port. A request with `we_i` low returns read data combinationally in the same cycle. A request with `we_i` high takes effect at the next clock edge. An out-of-map access raises `err_o` during the request cycle.

Top module: `slot_ctl_regs`

## Requirements
- R1: After reset the status word (word 2) reads 0x00000000 and `irq_o` is low.
- R2: Word 0 reads 0x41034003, word 1 reads 0x00000000 and word 3 reads 0x00000011, each with `err_o` low.
- R3: Status bit 0 equals the `wp_i` level as seen after two rising clock edges. It tracks both rising and falling changes of `wp_i` and is never latched.
- R4: A rising edge of `ins_i` sets status bit 3 and `irq_o` at the third rising clock edge after the change. Both then stay set when `ins_i` falls again.
- R5: A write to word 2 clears bit 3, and drops `irq_o` at the next edge, only when bit 3 of the written value is 1. The other written bits have no effect.
- R6: When a clearing write to word 2 meets an insert edge at the same clock edge, the set wins and bit 3 stays 1. An `ins_i` held high after a clear does not set bit 3 again without a new rising edge.
- R7: Writes to words 1 and 3 complete with `err_o` low. They change no readable word and do not change `irq_o`.
- R8: A request to any word above 3, or a write to word 0, drives `err_o` high in the request cycle. Such a read returns 0, and such a write changes no state.
- R9: Status bits other than 0 (write-protect) and 3 (insert) always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read request |
| err_o | output | 1 | Access error for the current request |
| wp_i | input | 1 | Asynchronous write-protect level from the slot |
| ins_i | input | 1 | Asynchronous card-insert level from the slot |
| irq_o | output | 1 | Card-insert interrupt, high while status bit 3 is set |

## Verification
The one piece of real state is the insert latch, and `irq_o` shows it directly. A latch that sets late, misses an edge, loses a set to a simultaneous clear, or re-arms on a held level therefore shows at the pin within one clock. The bench pins down the exact edge on which each input change appears: two edges for write-protect and three for insert. A wrong synchroniser depth shows up as a one-cycle early or late status bit. A decode slip shows up as a wrong constant word, a missing error flag, or a write that leaks into the status word.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NUM_WORDS = 4;
  localparam logic [DW-1:0] ID_VAL     = 32'h4103_4003;
  localparam logic [DW-1:0] DECODE_VAL = 32'h0000_0011;
  localparam int unsigned WP_BIT  = 0;
  localparam int unsigned INS_BIT = 3;

  typedef enum logic [1:0] {
    W_ID    = 2'd0,
    W_FLASH = 2'd1,
    W_STAT  = 2'd2,
    W_DEC   = 2'd3
  } word_e;

  typedef struct packed {
    logic ins;
    logic wp;
  } stat_t;
endpackage

// File: rtl/slot_ctl_sync.sv
module slot_ctl_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/slot_ctl_status.sv
module slot_ctl_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ins_s_i,
  input  logic clr_i,
  output logic ins_o
);
  logic prev_q, ins_q, rise;

  assign rise = ins_s_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      ins_q  <= 1'b0;
    end else begin
      prev_q <= ins_s_i;
      // set has priority so an insert event is never lost
      if (rise)       ins_q <= 1'b1;
      else if (clr_i) ins_q <= 1'b0;
    end
  end

  assign ins_o = ins_q;

  p_set_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> ins_q);
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q && !clr_i) |=> ins_q);
  p_no_spurious_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_q && !rise) |=> !ins_q);
  p_clear_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !ins_q);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && rise) |=> ins_q);
endmodule

// File: rtl/slot_ctl_decode.sv
module slot_ctl_decode
  import slot_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  stat_t             stat_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              clr_ins_o
);
  localparam int unsigned SEL_W = $clog2(NUM_WORDS);

  logic  in_map;
  word_e sel;
  logic  unused_wdata;

  assign in_map = (addr_i >> SEL_W) == '0;
  assign sel    = word_e'(addr_i[SEL_W-1:0]);
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rdata_o   = '0;
    err_o     = 1'b0;
    clr_ins_o = 1'b0;
    if (req_i) begin
      if (!in_map) begin
        err_o = 1'b1;
      end else if (we_i) begin
        unique case (sel)
          W_ID:   err_o = 1'b1;
          W_STAT: clr_ins_o = wdata_i[INS_BIT];
          default: ;  // flash and decode words swallow writes
        endcase
      end else begin
        unique case (sel)
          W_ID:    rdata_o = ID_VAL;
          W_FLASH: rdata_o = '0;
          W_STAT: begin
            rdata_o[WP_BIT]  = stat_i.wp;
            rdata_o[INS_BIT] = stat_i.ins;
          end
          W_DEC:   rdata_o = DECODE_VAL;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
  import slot_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  input  logic              wp_i,
  input  logic              ins_i,
  output logic              irq_o
);
  logic [1:0] raw, synced;
  logic       clr_ins, ins_lat;
  stat_t      stat;

  assign raw = {ins_i, wp_i};

  slot_ctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  slot_ctl_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ins_s_i(synced[1]),
    .clr_i  (clr_ins),
    .ins_o  (ins_lat)
  );

  assign stat.wp  = synced[0];
  assign stat.ins = ins_lat;

  slot_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .stat_i   (stat),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .clr_ins_o(clr_ins)
  );

  assign irq_o = ins_lat;

  p_wp_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(W_STAT)) |-> rdata_o[WP_BIT] == synced[0]);
  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0 && !clr_ins));
  p_err_keeps_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && irq_o) |=> irq_o);
  p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(W_STAT)) |-> rdata_o[DW-1:INS_BIT+1] == '0);
endmodule

// File: tb/tb_slot_ctl_regs.sv
module tb_slot_ctl_regs;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err, irq;
  logic          wp = 1'b0, ins = 1'b0;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  slot_ctl_regs #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .wp_i(wp), .ins_i(ins),
    .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(int a, logic [31:0] exp, logic exp_err, string tag);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    #1;
    chk({tag, " rdata"}, rdata, exp);
    chk({tag, " err"}, {31'd0, err}, {31'd0, exp_err});
    req = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d, logic exp_err, string tag);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    #1;
    chk({tag, " err"}, {31'd0, err}, {31'd0, exp_err});
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset;
    rd(2, 32'h0, 1'b0, "R1 status after reset");
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_const_words;
    rd(0, 32'h4103_4003, 1'b0, "R2 id word");
    rd(1, 32'h0, 1'b0, "R2 flash word");
    rd(3, 32'h11, 1'b0, "R2 decode word");
  endtask

  task automatic t_wp;
    wp = 1'b1;
    edges(1);
    rd(2, 32'h0, 1'b0, "R3 wp after one edge");
    edges(1);
    rd(2, 32'h1, 1'b0, "R3 wp after two edges");
    wp = 1'b0;
    edges(2);
    rd(2, 32'h0, 1'b0, "R3 wp falls");
  endtask

  task automatic t_insert;
    ins = 1'b1;
    edges(2);
    rd(2, 32'h0, 1'b0, "R4 insert after two edges");
    chk("R4 irq after two edges", {31'd0, irq}, 32'd0);
    edges(1);
    rd(2, 32'h8, 1'b0, "R4 insert after three edges");
    chk("R4 irq after three edges", {31'd0, irq}, 32'd1);
    ins = 1'b0;
    edges(4);
    rd(2, 32'h8, 1'b0, "R4 sticky after release");
    chk("R4 irq sticky", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_clear;
    wr(2, 32'hFFFF_FFF7, 1'b0, "R5 write without bit3");
    rd(2, 32'h8, 1'b0, "R5 bit3 kept");
    chk("R5 irq kept", {31'd0, irq}, 32'd1);
    wr(2, 32'h0000_0008, 1'b0, "R5 clearing write");
    rd(2, 32'h0, 1'b0, "R5 bit3 cleared");
    chk("R5 irq dropped", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_set_wins;
    ins = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(2); wdata = 32'h8;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(2, 32'h8, 1'b0, "R6 set beats clear");
    chk("R6 irq after collision", {31'd0, irq}, 32'd1);
    wr(2, 32'h8, 1'b0, "R6 clear with ins held");
    edges(4);
    chk("R6 no re-arm on held level", {31'd0, irq}, 32'd0);
    ins = 1'b0;
    edges(4);
  endtask

  task automatic t_ignored;
    ins = 1'b1;
    edges(3);
    ins = 1'b0;
    edges(3);
    wr(1, 32'hFFFF_FFFF, 1'b0, "R7 write flash word");
    wr(3, 32'hFFFF_FFFF, 1'b0, "R7 write decode word");
    rd(1, 32'h0, 1'b0, "R7 flash word unchanged");
    rd(3, 32'h11, 1'b0, "R7 decode word unchanged");
    rd(2, 32'h8, 1'b0, "R7 status unchanged");
    chk("R7 irq unchanged", {31'd0, irq}, 32'd1);
    wr(2, 32'h0000_0007, 1'b0, "R5 low bits write");
    rd(2, 32'h8, 1'b0, "R5 low bits no effect");
  endtask

  task automatic t_errors;
    wr(0, 32'h0, 1'b1, "R8 write id word");
    rd(0, 32'h4103_4003, 1'b0, "R8 id unchanged");
    rd(4, 32'h0, 1'b1, "R8 read word 4");
    rd(63, 32'h0, 1'b1, "R8 read word 63");
    wr(6, 32'h8, 1'b1, "R8 write word 6");
    chk("R8 irq kept after bad write", {31'd0, irq}, 32'd1);
    wr(34, 32'h8, 1'b1, "R8 aliasing write");
    rd(2, 32'h8, 1'b0, "R8 status kept");
  endtask

  task automatic t_reserved;
    wp = 1'b1;
    edges(2);
    rd(2, 32'h9, 1'b0, "R9 only bits 0 and 3");
    wp = 1'b0;
    edges(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    edges(1);
    t_reset();
    t_const_words();
    t_wp();
    t_insert();
    t_clear();
    t_set_wins();
    t_ignored();
    t_errors();
    t_reserved();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule